// File: doc/BRIEF.md
# Non-blocking Flow Key-Value Cache

This block holds per-flow state on chip in a set-associative store and takes one key per clock without ever pausing. Each accepted key is looked up in the set chosen by its low bits. When the key is resident, its stored value goes out to an external fold circuit. The folded result comes back in the same cycle and replaces the stored value. When the key is absent, the block does not fetch anything from off-chip memory. It treats the key as a fresh flow and hands the fold circuit the fixed starting value instead. The key is then installed in a free way or, when the set is full, in the least recently used way.

Each resident entry keeps a count of the packets it has absorbed since it was installed. A displaced entry leaves as an eviction record of key, value and count. These records pass through a small queue onto a valid/ready stream, where downstream logic can merge them into the large store. Back-pressure on that stream never reaches the lookup side. If the queue is full when a record arrives, the record is discarded and a drop counter advances.

Top module: `kv_flow_cache`

## Requirements
- R1: While reset is held and right after it, `fold_valid` and `ev_valid` are 0, `drop_count` is 0, and the store is empty, so every first lookup misses.
- R2: A key offered with `req_valid` high is always taken; one cycle later `fold_valid` is high with `fold_key` equal to that key, and `fold_valid` is low one cycle after an idle input.
- R3: On a hit, `fold_old` carries the value last written for that key, and `fold_new` becomes the key's stored value.
- R4: On a miss, `fold_old` equals the parameter `INIT_VAL`; nothing is read from off-chip, and `fold_new` is stored as the new entry's value.
- R5: The set is selected by key bits [IDX_W-1:0], and all KEY_W bits are compared, so keys that differ only in their upper bits are separate entries.
- R6: A miss in a set whose WAYS entries are all valid emits one eviction record holding the victim's key, value and count.
- R7: An entry's count is 1 after the packet that installs it, and each later hit adds 1, saturating at its maximum; the eviction record carries this count.
- R8: The victim is the least recently used entry of the set, where a hit or an install makes that entry the most recent.
- R9: Lookups to the same set or the same key on consecutive cycles see the results of the update made the cycle before.
- R10: While `ev_valid` is high and `ev_ready` is low, the eviction record holds still; records leave in the order the evictions happened.
- R11: A record produced while the queue already holds EV_DEPTH records is discarded and `drop_count` rises by 1; lookups go on unaffected.
- R12: A miss in a set with an invalid way fills that way and produces no eviction record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A lookup key is offered this cycle (never refused) |
| req_key | input | KEY_W | Flow key |
| fold_valid | output | 1 | The fold interface carries a lookup this cycle |
| fold_key | output | KEY_W | Key being folded |
| fold_old | output | VAL_W | Stored value on a hit, INIT_VAL on a miss |
| fold_new | input | VAL_W | Folded value, returned combinationally |
| ev_valid | output | 1 | An eviction record is available |
| ev_ready | input | 1 | The consumer takes the record when high together with ev_valid |
| ev_key | output | KEY_W | Key of the evicted entry |
| ev_val | output | VAL_W | Value of the evicted entry |
| ev_cnt | output | CNT_W | Packets the evicted entry absorbed while resident |
| drop_count | output | DROP_W | Number of eviction records discarded on a full queue |

## Verification
Two events can fall in the same cycle. A read of a set can coincide with the write-back of that set from the lookup one cycle earlier. An eviction push can also coincide with a pop from the stream, or arrive while the queue is full. The bench provokes the first with runs of the same key and with alternating keys in one set. It provokes the second by stalling `ev_ready` during a burst of misses into full sets and then toggling it. Both are judged against a behavioural model that keeps per-set recency lists and an eviction queue. The model compares the fold and eviction outputs and the drop counter every cycle.

// File: rtl/kvc_pkg.sv
package kvc_pkg;

  // Result of looking a key up in one set
  typedef enum logic [1:0] {
    KVC_HIT   = 2'd0,
    KVC_FILL  = 2'd1,
    KVC_EVICT = 2'd2
  } kvc_outcome_e;

endpackage

// File: rtl/kvc_set_ctrl.sv
// Tag compare, way choice and recency-age update for one set.
module kvc_set_ctrl
  import kvc_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int KEY_W = 128,
  parameter int AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_vld,
  input  logic [KEY_W-1:0] way_key  [WAYS],
  input  logic [AGE_W-1:0] way_age  [WAYS],
  input  logic [KEY_W-1:0] key,
  output kvc_outcome_e     outcome,
  output logic [AGE_W-1:0] sel_way,
  output logic [AGE_W-1:0] next_age [WAYS]
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [WAYS-1:0]  match;
  logic [AGE_W-1:0] hit_way, free_way, victim_way, ref_age;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = way_vld[g] && (way_key[g] == key);
  end

  always_comb begin
    hit_way    = '0;
    free_way   = '0;
    victim_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i])                                  hit_way    = AGE_W'(i);
      if (!way_vld[i])                               free_way   = AGE_W'(i);
      if (way_vld[i] && (way_age[i] == OLDEST))      victim_way = AGE_W'(i);
    end
    if (|match) begin
      outcome = KVC_HIT;
      sel_way = hit_way;
      ref_age = way_age[hit_way];
    end else if (&way_vld) begin
      outcome = KVC_EVICT;
      sel_way = victim_way;
      ref_age = OLDEST;
    end else begin
      outcome = KVC_FILL;
      sel_way = free_way;
      ref_age = OLDEST;
    end
  end

  // Entries younger than the touched one grow one step older
  for (genvar g = 0; g < WAYS; g++) begin : g_age
    always_comb begin
      if (AGE_W'(g) == sel_way)
        next_age[g] = '0;
      else if (way_vld[g] && (way_age[g] < ref_age))
        next_age[g] = way_age[g] + AGE_W'(1);
      else
        next_age[g] = way_age[g];
    end
  end

endmodule

// File: rtl/kvc_evict_fifo.sv
// Eviction record queue: push never stalls, overflow is counted and dropped.
module kvc_evict_fifo #(
  parameter int W      = 272,
  parameter int DEPTH  = 4,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [W-1:0]      push_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_data,
  output logic [DROP_W-1:0] drop_count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_AT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] used;
  logic             accept, take;

  assign accept    = push && (used != FULL_AT);
  assign take      = out_valid && out_ready;
  assign out_valid = (used != '0);
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      used       <= '0;
      drop_count <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (take)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      if (accept && !take)      used <= used + CNT_W'(1);
      else if (!accept && take) used <= used - CNT_W'(1);
      if (push && !accept) drop_count <= drop_count + DROP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/kv_flow_cache.sv
// Two-stage non-blocking set-associative flow cache.
// Stage A registers the key and a snapshot of its set (bypassed from the
// write-back in flight when the set matches); stage B folds and writes back.
module kv_flow_cache
  import kvc_pkg::*;
#(
  parameter int               KEY_W    = 128,
  parameter int               VAL_W    = 128,
  parameter int               CNT_W    = 16,
  parameter int               WAYS     = 8,
  parameter int               SETS     = 16,
  parameter int               EV_DEPTH = 4,
  parameter int               DROP_W   = 16,
  parameter logic [VAL_W-1:0] INIT_VAL = VAL_W'(256)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [KEY_W-1:0]  req_key,
  output logic              fold_valid,
  output logic [KEY_W-1:0]  fold_key,
  output logic [VAL_W-1:0]  fold_old,
  input  logic [VAL_W-1:0]  fold_new,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [KEY_W-1:0]  ev_key,
  output logic [VAL_W-1:0]  ev_val,
  output logic [CNT_W-1:0]  ev_cnt,
  output logic [DROP_W-1:0] drop_count
);

  localparam int IDX_W = $clog2(SETS);
  localparam int AGE_W = $clog2(WAYS);
  localparam int REC_W = KEY_W + VAL_W + CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Backing arrays of the on-chip store
  logic [WAYS-1:0]  st_vld [SETS];
  logic [KEY_W-1:0] st_key [SETS][WAYS];
  logic [VAL_W-1:0] st_val [SETS][WAYS];
  logic [CNT_W-1:0] st_cnt [SETS][WAYS];
  logic [AGE_W-1:0] st_age [SETS][WAYS];

  // Stage A registers: request and set snapshot
  logic             a_vld;
  logic [KEY_W-1:0] a_key;
  logic [IDX_W-1:0] a_idx;
  logic [WAYS-1:0]  s_vld;
  logic [KEY_W-1:0] s_key [WAYS];
  logic [VAL_W-1:0] s_val [WAYS];
  logic [CNT_W-1:0] s_cnt [WAYS];
  logic [AGE_W-1:0] s_age [WAYS];

  // Stage B: updated set contents
  logic [WAYS-1:0]  n_vld;
  logic [KEY_W-1:0] n_key [WAYS];
  logic [VAL_W-1:0] n_val [WAYS];
  logic [CNT_W-1:0] n_cnt [WAYS];
  logic [AGE_W-1:0] n_age [WAYS];
  logic [AGE_W-1:0] nx_age [WAYS];

  kvc_outcome_e     outcome;
  logic [AGE_W-1:0] sel_way;
  logic [IDX_W-1:0] r_idx;
  logic             bypass;
  logic             ev_push;
  logic [REC_W-1:0] ev_rec_in, ev_rec_out;

  assign r_idx  = req_key[IDX_W-1:0];
  assign bypass = a_vld && (a_idx == r_idx);

  kvc_set_ctrl #(
    .WAYS  (WAYS),
    .KEY_W (KEY_W),
    .AGE_W (AGE_W)
  ) u_set_ctrl (
    .way_vld  (s_vld),
    .way_key  (s_key),
    .way_age  (s_age),
    .key      (a_key),
    .outcome  (outcome),
    .sel_way  (sel_way),
    .next_age (nx_age)
  );

  assign fold_valid = a_vld;
  assign fold_key   = a_key;
  assign fold_old   = (outcome == KVC_HIT) ? s_val[sel_way] : INIT_VAL;

  always_comb begin
    n_vld = s_vld;
    for (int w = 0; w < WAYS; w++) begin
      n_key[w] = s_key[w];
      n_val[w] = s_val[w];
      n_cnt[w] = s_cnt[w];
      n_age[w] = nx_age[w];
    end
    n_vld[sel_way] = 1'b1;
    n_key[sel_way] = a_key;
    n_val[sel_way] = fold_new;
    if (outcome == KVC_HIT)
      n_cnt[sel_way] = (s_cnt[sel_way] == CNT_MAX) ? CNT_MAX
                                                   : s_cnt[sel_way] + CNT_W'(1);
    else
      n_cnt[sel_way] = CNT_W'(1);
  end

  // Valid bits and pipeline valid carry reset
  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld <= 1'b0;
      for (int s = 0; s < SETS; s++) st_vld[s] <= '0;
    end else begin
      a_vld <= req_valid;
      if (a_vld) st_vld[a_idx] <= n_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) s_vld <= bypass ? n_vld : st_vld[r_idx];
  end

  // Payload arrays and snapshot need no reset
  always_ff @(posedge clk) begin
    if (a_vld) begin
      for (int w = 0; w < WAYS; w++) begin
        st_key[a_idx][w] <= n_key[w];
        st_val[a_idx][w] <= n_val[w];
        st_cnt[a_idx][w] <= n_cnt[w];
        st_age[a_idx][w] <= n_age[w];
      end
    end
    if (req_valid) begin
      a_key <= req_key;
      a_idx <= r_idx;
      for (int w = 0; w < WAYS; w++) begin
        s_key[w] <= bypass ? n_key[w] : st_key[r_idx][w];
        s_val[w] <= bypass ? n_val[w] : st_val[r_idx][w];
        s_cnt[w] <= bypass ? n_cnt[w] : st_cnt[r_idx][w];
        s_age[w] <= bypass ? n_age[w] : st_age[r_idx][w];
      end
    end
  end

  assign ev_push   = a_vld && (outcome == KVC_EVICT);
  assign ev_rec_in = {s_key[sel_way], s_val[sel_way], s_cnt[sel_way]};

  kvc_evict_fifo #(
    .W      (REC_W),
    .DEPTH  (EV_DEPTH),
    .DROP_W (DROP_W)
  ) u_evict_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (ev_push),
    .push_data  (ev_rec_in),
    .out_valid  (ev_valid),
    .out_ready  (ev_ready),
    .out_data   (ev_rec_out),
    .drop_count (drop_count)
  );

  assign {ev_key, ev_val, ev_cnt} = ev_rec_out;

endmodule

// File: rtl/kv_flow_cache_chk.sv
module kv_flow_cache_chk #(
  parameter int KEY_W  = 128,
  parameter int VAL_W  = 128,
  parameter int CNT_W  = 16,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              fold_valid,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [KEY_W-1:0]  ev_key,
  input logic [VAL_W-1:0]  ev_val,
  input logic [CNT_W-1:0]  ev_cnt,
  input logic [DROP_W-1:0] drop_count
);

  AST_FOLD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> fold_valid); // R2

  AST_IDLE_NO_FOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !fold_valid); // R2

  AST_EV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_key) && $stable(ev_val) && $stable(ev_cnt))); // R10

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
    (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1)); // R11

  AST_EV_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (ev_cnt != '0)); // R7

  AST_EV_AFTER_FOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_valid) |-> $past(fold_valid)); // R6

endmodule

bind kv_flow_cache kv_flow_cache_chk #(
  .KEY_W  (KEY_W),
  .VAL_W  (VAL_W),
  .CNT_W  (CNT_W),
  .DROP_W (DROP_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .fold_valid (fold_valid),
  .ev_valid   (ev_valid),
  .ev_ready   (ev_ready),
  .ev_key     (ev_key),
  .ev_val     (ev_val),
  .ev_cnt     (ev_cnt),
  .drop_count (drop_count)
);

// File: tb/kv_flow_cache_test.sv
`timescale 1ns/1ps
module kv_flow_cache_test;

  localparam int KW = 128;
  localparam int CW = 16;
  localparam int DW = 16;
  localparam int NW = 8;
  localparam int NS = 16;
  localparam int IW = 4;
  localparam int FD = 4;
  localparam logic [KW-1:0] V0 = KW'(256);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [KW-1:0] req_key = '0;
  logic          fold_valid;
  logic [KW-1:0] fold_key, fold_old, fold_new;
  logic          ev_valid;
  logic          ev_ready = 1'b0;
  logic [KW-1:0] ev_key, ev_val;
  logic [CW-1:0] ev_cnt;
  logic [DW-1:0] drop_count;

  always #5 clk = ~clk;

  // External fold: value + low key byte + 1
  assign fold_new = fold_old + KW'(fold_key[7:0]) + KW'(1);

  kv_flow_cache #(
    .KEY_W(KW), .VAL_W(KW), .CNT_W(CW), .WAYS(NW), .SETS(NS),
    .EV_DEPTH(FD), .DROP_W(DW), .INIT_VAL(V0)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_key(req_key),
    .fold_valid(fold_valid), .fold_key(fold_key), .fold_old(fold_old),
    .fold_new(fold_new), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_key(ev_key), .ev_val(ev_val), .ev_cnt(ev_cnt), .drop_count(drop_count)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string cur_tag = "R1";

  // Reference model: per-set recency lists, most recent first
  logic [KW-1:0] mk [NS][$];
  logic [KW-1:0] mv [NS][$];
  int            mc [NS][$];
  logic [KW-1:0] qk [$];
  logic [KW-1:0] qv [$];
  int            qc [$];
  int            drops = 0;
  logic          pend_v = 1'b0;
  logic [KW-1:0] pend_k = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [KW-1:0] act, input logic [KW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [KW-1:0] k, input logic rdy);
    int            s, hp, sz0, c;
    logic          push;
    logic [KW-1:0] eo, nv, pk, pv;
    int            pc;
    @(negedge clk);
    // Eviction stream and drop counter
    if (qk.size() > 0) begin
      chk(ev_valid === 1'b1, cur_tag, "ev_valid", KW'(ev_valid), KW'(1));
      if (ev_valid === 1'b1) begin
        chk(ev_key === qk[0], cur_tag, "ev_key", ev_key, qk[0]);
        chk(ev_val === qv[0], cur_tag, "ev_val", ev_val, qv[0]);
        chk(ev_cnt === CW'(qc[0]), "R7", "ev_cnt", KW'(ev_cnt), KW'(qc[0]));
      end
    end else begin
      chk(ev_valid === 1'b0, "R12", "ev_valid idle", KW'(ev_valid), KW'(0));
    end
    chk(drop_count === DW'(drops), "R11", "drop_count", KW'(drop_count), KW'(drops));
    chk(fold_valid === pend_v, "R2", "fold_valid", KW'(fold_valid), KW'(pend_v));
    push = 1'b0;
    pk = '0; pv = '0; pc = 0;
    if (pend_v) begin
      chk(fold_key === pend_k, "R2", "fold_key", fold_key, pend_k);
      s  = int'(pend_k[IW-1:0]);
      hp = -1;
      for (int i = 0; i < mk[s].size(); i++) if (mk[s][i] == pend_k) hp = i;
      eo = (hp >= 0) ? mv[s][hp] : V0;
      chk(fold_old === eo, cur_tag, (hp >= 0) ? "fold_old hit" : "fold_old miss", fold_old, eo);
      nv = eo + KW'(pend_k[7:0]) + KW'(1);
      if (hp >= 0) begin
        c = mc[s][hp] + 1;
        if (c > 65535) c = 65535;
        mk[s].delete(hp); mv[s].delete(hp); mc[s].delete(hp);
      end else begin
        c = 1;
        if (mk[s].size() == NW) begin
          push = 1'b1;
          pk = mk[s].pop_back(); pv = mv[s].pop_back(); pc = mc[s].pop_back();
        end
      end
      mk[s].push_front(pend_k); mv[s].push_front(nv); mc[s].push_front(c);
    end
    sz0 = qk.size();
    if (push) begin
      if (sz0 < FD) begin qk.push_back(pk); qv.push_back(pv); qc.push_back(pc); end
      else drops++;
    end
    if (sz0 > 0 && rdy) begin
      void'(qk.pop_front()); void'(qv.pop_front()); void'(qc.pop_front());
    end
    req_valid = v; req_key = k; ev_ready = rdy;
    pend_v = v; pend_k = k;
  endtask

  function automatic logic [KW-1:0] key_of(input int set, input int j);
    return KW'(set) + (KW'(j) << IW);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(fold_valid === 1'b0, "R1", "fold_valid in reset", KW'(fold_valid), '0);
    chk(ev_valid === 1'b0, "R1", "ev_valid in reset", KW'(ev_valid), '0);
    chk(drop_count === '0, "R1", "drop_count in reset", KW'(drop_count), '0);
    rst = 1'b0;
    step(1'b0, '0, 1'b1);

    // R12: fill set 3 with free ways, back to back
    cur_tag = "R12";
    for (int j = 0; j < NW; j++) step(1'b1, key_of(3, j), 1'b1);

    // R3: hits on resident keys, with idle gaps
    cur_tag = "R3";
    step(1'b1, key_of(3, 0), 1'b1);
    step(1'b0, '0, 1'b1);
    step(1'b1, key_of(3, 5), 1'b1);
    step(1'b0, '0, 1'b1);

    // R8: new key evicts the least recent (key j=1)
    cur_tag = "R8";
    step(1'b1, key_of(3, 8), 1'b1);
    step(1'b1, key_of(3, 9), 1'b1);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);

    // R9: same key and same set on consecutive cycles
    cur_tag = "R9";
    for (int i = 0; i < 5; i++) step(1'b1, key_of(3, 0), 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, key_of(3, (i % 2 == 0) ? 5 : 8), 1'b1);

    // R5: keys differing only in upper bits
    cur_tag = "R5";
    step(1'b1, KW'(7), 1'b1);
    step(1'b1, (KW'(1) << 127) | KW'(7), 1'b1);
    step(1'b1, (KW'(1) << 64) | KW'(7), 1'b1);
    step(1'b1, KW'(7), 1'b1);
    step(1'b1, (KW'(1) << 127) | KW'(7), 1'b1);

    // R6: repeated evictions with ready high
    cur_tag = "R6";
    for (int j = 0; j < 12; j++) step(1'b1, key_of(9, j), 1'b1);
    for (int j = 0; j < 4; j++) step(1'b0, '0, 1'b1);

    // R11: ready held low while evictions overflow the queue
    cur_tag = "R11";
    for (int j = 0; j < 20; j++) step(1'b1, key_of(5, j), 1'b0);
    step(1'b0, '0, 1'b0);

    // R10: ready toggling while more evictions arrive
    cur_tag = "R10";
    for (int j = 20; j < 34; j++) step(1'b1, key_of(5, j), (j % 3) == 0);
    for (int j = 0; j < 12; j++) step(1'b0, '0, (j % 2) == 0);

    // R4: mixed random traffic over few sets
    cur_tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      int unsigned st, jj, vv, rr;
      st = $urandom_range(3, 0);
      jj = $urandom_range(11, 0);
      vv = $urandom_range(9, 0);
      rr = $urandom_range(3, 0);
      step(vv < 8, key_of(int'(st), int'(jj)), rr != 0);
    end
    for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule